// File: doc/BRIEF.md
# Countdown Interval Timer with Coherent Count Capture

A countdown timer that sits on a 16-bit processor bus and exposes six 16-bit words: status, control, low and high halves of a 32-bit reload value, and low and high halves of a captured count. A 32-bit counter counts down while the timer runs. At the clock edge where it is already at zero, it reloads from the reload value and signals a timeout. Software chooses between a single countdown and free-running repetition. It can gate an interrupt from the sticky timeout flag.

Each timeout also produces a one-cycle pulse. When the watchdog variant is configured, the same pulse appears on a reset output. A 32-bit count cannot be read atomically over a 16-bit bus. Software therefore writes to either capture word, which freezes the whole count into a holding register, and then reads the two halves at leisure. Read data is combinational from the word address; writes take effect on the rising clock edge.

Top module: `snap_timer`

## Requirements
- R1: After reset the status and control words read 0, both reload halves read the RESET_PERIOD halves (0xFFFF each by default), and irq_o, pulse_o and wd_rst_o are low.
- R2: Word addresses are 0 status, 1 control, 2 reload low, 3 reload high, 4 capture low, 5 capture high; reads of addresses 6 and 7 return 0.
- R3: Control write bits are bit 0 interrupt enable, bit 1 continuous mode, bit 2 start, bit 3 stop, with stop winning over start; control reads back bits 0 and 1 only, and status bit 1 reads 1 while the timer runs.
- R4: Writing either reload half updates that half, stops the timer, and loads the counter with the full new 32-bit reload value.
- R5: While running, the counter decrements by one each cycle; at an edge where it is 0 it reloads and signals a timeout, so a reload value P gives one timeout every P+1 cycles, and every cycle when P is 0.
- R6: In single mode (control bit 1 clear), the timer stops after its first timeout; in continuous mode it keeps running until stopped.
- R7: Status bit 0 is a sticky timeout flag; any write to the status word clears it, and a timeout in the same cycle keeps it set.
- R8: irq_o is high exactly when the timeout flag and the interrupt enable bit are both set.
- R9: pulse_o is high for the one cycle that follows each timeout edge.
- R10: A write to word 4 or 5 captures the counter value held before that edge; the capture words keep returning that value as low and high halves until the next capture write.
- R11: With WD_EN set (the default), wd_rst_o follows pulse_o; with WD_EN clear, it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Word address |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| irq_o | output | 1 | Interrupt request |
| pulse_o | output | 1 | One-cycle timeout pulse |
| wd_rst_o | output | 1 | Watchdog reset request |

## Verification
A corrupt counter or run bit shows up as a missing, early or extra pulse_o. The scoreboard compares every pulse with the cycle number the reload value predicts, so the error is caught on the first timeout it disturbs: at most P+1 cycles later. A wrong capture path returns a wrong half on the first read after a capture write. The test uses a reload value whose high half must borrow, so a capture that misses that borrow is exposed at once. A flag or enable error appears on irq_o or in status bit 0 in the cycle after the write that should have changed it.

// File: rtl/snap_timer_pkg.sv
package snap_timer_pkg;
  localparam int REG_W  = 16;
  localparam int CNT_W  = 2 * REG_W;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_STATUS  = 3'd0,
    SEL_CTRL    = 3'd1,
    SEL_PER_LO  = 3'd2,
    SEL_PER_HI  = 3'd3,
    SEL_SNAP_LO = 3'd4,
    SEL_SNAP_HI = 3'd5
  } reg_sel_e;

  localparam int CTRL_IRQ_EN = 0;
  localparam int CTRL_CONT   = 1;
  localparam int CTRL_START  = 2;
  localparam int CTRL_STOP   = 3;

  localparam int STAT_TIMEOUT = 0;
  localparam int STAT_RUN     = 1;

  typedef struct packed {
    logic cont;
    logic irq_en;
  } ctrl_t;
endpackage

// File: rtl/snap_timer_regs.sv
module snap_timer_regs
  import snap_timer_pkg::*;
#(
  parameter logic [CNT_W-1:0] RESET_PERIOD = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              run_i,
  input  logic              flag_i,
  input  logic [CNT_W-1:0]  snap_i,
  output logic [REG_W-1:0]  rdata_o,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  period_o,
  output logic              period_wr_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              status_wr_o,
  output logic              snap_wr_o
);
  ctrl_t            ctrl_q;
  logic [REG_W-1:0] per_lo_q, per_hi_q;
  logic             wr_ctrl, wr_lo, wr_hi;

  assign wr_ctrl     = wr_en_i && (addr_i == SEL_CTRL);
  assign wr_lo       = wr_en_i && (addr_i == SEL_PER_LO);
  assign wr_hi       = wr_en_i && (addr_i == SEL_PER_HI);
  assign status_wr_o = wr_en_i && (addr_i == SEL_STATUS);
  assign snap_wr_o   = wr_en_i && ((addr_i == SEL_SNAP_LO) || (addr_i == SEL_SNAP_HI));
  assign period_wr_o = wr_lo || wr_hi;
  assign start_o     = wr_ctrl && wdata_i[CTRL_START];
  assign stop_o      = wr_ctrl && wdata_i[CTRL_STOP];

  // next reload value, so a reload write is seen by the counter in the same edge
  assign period_o = {wr_hi ? wdata_i : per_hi_q, wr_lo ? wdata_i : per_lo_q};
  assign ctrl_o   = ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      per_lo_q <= RESET_PERIOD[REG_W-1:0];
      per_hi_q <= RESET_PERIOD[CNT_W-1:REG_W];
    end else begin
      if (wr_ctrl) begin
        ctrl_q.irq_en <= wdata_i[CTRL_IRQ_EN];
        ctrl_q.cont   <= wdata_i[CTRL_CONT];
      end
      if (wr_lo) per_lo_q <= wdata_i;
      if (wr_hi) per_hi_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      SEL_STATUS: begin
        rdata_o[STAT_TIMEOUT] = flag_i;
        rdata_o[STAT_RUN]     = run_i;
      end
      SEL_CTRL: begin
        rdata_o[CTRL_IRQ_EN] = ctrl_q.irq_en;
        rdata_o[CTRL_CONT]   = ctrl_q.cont;
      end
      SEL_PER_LO:  rdata_o = per_lo_q;
      SEL_PER_HI:  rdata_o = per_hi_q;
      SEL_SNAP_LO: rdata_o = snap_i[REG_W-1:0];
      SEL_SNAP_HI: rdata_o = snap_i[CNT_W-1:REG_W];
      default:     rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/snap_timer_counter.sv
module snap_timer_counter
  import snap_timer_pkg::*;
#(
  parameter logic [CNT_W-1:0] RESET_PERIOD = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             period_wr_i,
  input  logic             cont_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             run_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             evt_o
);
  logic             run_q;
  logic [CNT_W-1:0] cnt_q;

  assign evt_o = run_q && (cnt_q == '0);
  assign run_o = run_q;
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= RESET_PERIOD;
    end else begin
      if (period_wr_i)          run_q <= 1'b0;
      else if (stop_i)          run_q <= 1'b0;
      else if (start_i)         run_q <= 1'b1;
      else if (evt_o && !cont_i) run_q <= 1'b0;

      if (period_wr_i)  cnt_q <= period_i;
      else if (evt_o)   cnt_q <= period_i;
      else if (run_q)   cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/snap_timer_events.sv
module snap_timer_events
  import snap_timer_pkg::*;
#(
  parameter bit WD_EN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic             status_wr_i,
  input  logic             snap_wr_i,
  input  logic             irq_en_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             flag_o,
  output logic             irq_o,
  output logic             pulse_o,
  output logic             wd_rst_o,
  output logic [CNT_W-1:0] snap_o
);
  logic             flag_q, pulse_q;
  logic [CNT_W-1:0] snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
      snap_q  <= '0;
    end else begin
      pulse_q <= evt_i;
      if (evt_i)            flag_q <= 1'b1;   // set beats clear
      else if (status_wr_i) flag_q <= 1'b0;
      if (snap_wr_i) snap_q <= cnt_i;
    end
  end

  assign flag_o  = flag_q;
  assign irq_o   = flag_q && irq_en_i;
  assign pulse_o = pulse_q;
  assign snap_o  = snap_q;

  generate
    if (WD_EN) begin : g_wd
      assign wd_rst_o = pulse_q;
    end else begin : g_no_wd
      assign wd_rst_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/snap_timer.sv
module snap_timer
  import snap_timer_pkg::*;
#(
  parameter logic [CNT_W-1:0] RESET_PERIOD = '1,
  parameter bit               WD_EN        = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_o,
  output logic              pulse_o,
  output logic              wd_rst_o
);
  ctrl_t            ctrl;
  logic             irq_en, cont;
  logic [CNT_W-1:0] period, cnt, snap;
  logic             period_wr, start, stop, status_wr, snap_wr;
  logic             run, evt, flag;

  assign irq_en = ctrl.irq_en;
  assign cont   = ctrl.cont;

  snap_timer_regs #(.RESET_PERIOD(RESET_PERIOD)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .wr_en_i    (wr_en_i),
    .wdata_i    (wdata_i),
    .run_i      (run),
    .flag_i     (flag),
    .snap_i     (snap),
    .rdata_o    (rdata_o),
    .ctrl_o     (ctrl),
    .period_o   (period),
    .period_wr_o(period_wr),
    .start_o    (start),
    .stop_o     (stop),
    .status_wr_o(status_wr),
    .snap_wr_o  (snap_wr)
  );

  snap_timer_counter #(.RESET_PERIOD(RESET_PERIOD)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .stop_i     (stop),
    .period_wr_i(period_wr),
    .cont_i     (cont),
    .period_i   (period),
    .run_o      (run),
    .cnt_o      (cnt),
    .evt_o      (evt)
  );

  snap_timer_events #(.WD_EN(WD_EN)) u_evt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt),
    .status_wr_i(status_wr),
    .snap_wr_i  (snap_wr),
    .irq_en_i   (irq_en),
    .cnt_i      (cnt),
    .flag_o     (flag),
    .irq_o      (irq_o),
    .pulse_o    (pulse_o),
    .wd_rst_o   (wd_rst_o),
    .snap_o     (snap)
  );
endmodule

// File: rtl/snap_timer_chk.sv
module snap_timer_chk
  import snap_timer_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run,
  input logic             evt,
  input logic             cont,
  input logic             start,
  input logic             irq_en,
  input logic             flag,
  input logic             period_wr,
  input logic             status_wr,
  input logic             snap_wr,
  input logic [CNT_W-1:0] period,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] snap,
  input logic             irq_o,
  input logic             pulse_o,
  input logic             wd_rst_o
);
  p_period_wr_stops_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(period_wr) |-> (!run && cnt == $past(period)));

  p_decrement_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(run && !evt && !period_wr) |-> cnt == $past(cnt) - 1'b1);

  p_reload_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(evt && !period_wr) |-> cnt == $past(period));

  p_oneshot_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(evt && !cont && !start) |-> !run);

  p_flag_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(evt) |-> flag);

  p_flag_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(flag && !status_wr) |-> flag);

  p_irq_gated_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag && irq_en));

  p_pulse_from_evt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o == $past(evt));

  p_snap_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(snap_wr) |-> $stable(snap));

  p_wd_follows_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_rst_o |-> pulse_o);
endmodule

bind snap_timer snap_timer_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .run      (run),
  .evt      (evt),
  .cont     (cont),
  .start    (start),
  .irq_en   (irq_en),
  .flag     (flag),
  .period_wr(period_wr),
  .status_wr(status_wr),
  .snap_wr  (snap_wr),
  .period   (period),
  .cnt      (cnt),
  .snap     (snap),
  .irq_o    (irq_o),
  .pulse_o  (pulse_o),
  .wd_rst_o (wd_rst_o)
);

// File: tb/snap_timer_test.sv
`timescale 1ns/1ps
module snap_timer_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        irq_o, pulse_o, wd_rst_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit done    = 1'b0;
  int exp_q[$];

  always #10 clk_i = ~clk_i;  // 50 MHz
  always @(posedge clk_i) cyc <= cyc + 1;

  snap_timer uut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .wr_en_i (wr_en_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o),
    .pulse_o (pulse_o),
    .wd_rst_o(wd_rst_o)
  );

  // monitor: every pulse must match the next expected cycle
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (pulse_o) begin
        n_tests++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R9 unexpected pulse at cycle %0d, expected none", cyc);
        end else begin
          int e;
          e = exp_q.pop_front();
          if (e != cyc) begin
            n_fail++;
            $display("FAIL R5 pulse at cycle %0d, expected %0d", cyc, e);
          end
        end
        n_tests++;
        if (wd_rst_o !== 1'b1) begin
          n_fail++;
          $display("FAIL R11 wd_rst_o=%b, expected 1", wd_rst_o);
        end
      end else if (wd_rst_o !== 1'b0) begin
        n_tests++;
        n_fail++;
        $display("FAIL R11 wd_rst_o=%b without pulse, expected 0", wd_rst_o);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [15:0] exp);
    addr_i = a;
    #1;
    chk(req, rdata_o, exp);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // driver: start continuous run with reload p, expect n pulses, then stop
  task automatic run_cont(input int p, input int n);
    int s, last;
    s = cyc + 1;
    for (int k = 1; k <= n; k++) exp_q.push_back(s + k * (p + 1));
    last = s + n * (p + 1);
    if (p == 0) exp_q.push_back(last + 1);  // stop lands with run still high
    wr(3'd1, 16'h0006);
    rd_chk("R3 running bit", 3'd0, 16'h0002);
    rd_chk("R3 control readback", 3'd1, 16'h0002);
    while (cyc != last) @(negedge clk_i);
    wr(3'd1, 16'h0008);
  endtask

  initial begin
    int s;
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    rd_chk("R1 status", 3'd0, 16'h0000);
    rd_chk("R1 control", 3'd1, 16'h0000);
    rd_chk("R1 reload low", 3'd2, 16'hFFFF);
    rd_chk("R1 reload high", 3'd3, 16'hFFFF);
    chk("R1 outputs", {13'd0, irq_o, pulse_o, wd_rst_o}, 16'h0000);
    rd_chk("R2 address 6", 3'd6, 16'h0000);
    rd_chk("R2 address 7", 3'd7, 16'h0000);

    wr(3'd2, 16'h0005);
    rd_chk("R4 reload low", 3'd2, 16'h0005);
    wr(3'd3, 16'h0000);
    rd_chk("R4 reload high", 3'd3, 16'h0000);
    wr(3'd4, 16'h0000);
    rd_chk("R10 capture low idle", 3'd4, 16'h0005);
    rd_chk("R10 capture high idle", 3'd5, 16'h0000);

    run_cont(5, 3);
    rd_chk("R3 stopped, R7 flag", 3'd0, 16'h0001);
    chk("R8 irq disabled", {15'd0, irq_o}, 16'h0000);
    wait_cyc(15);
    wr(3'd1, 16'h0001);
    chk("R8 irq enabled", {15'd0, irq_o}, 16'h0001);
    wr(3'd0, 16'h0000);
    chk("R7 flag clear drops irq", {15'd0, irq_o}, 16'h0000);
    rd_chk("R7 status cleared", 3'd0, 16'h0000);
    wr(3'd1, 16'h0000);

    wr(3'd2, 16'h0000);
    run_cont(0, 4);
    wait_cyc(5);
    wr(3'd0, 16'h0000);

    // single mode, reload 3
    wr(3'd2, 16'h0003);
    s = cyc + 1;
    exp_q.push_back(s + 4);
    wr(3'd1, 16'h0004);
    wait_cyc(20);
    rd_chk("R6 single run ends", 3'd0, 16'h0001);
    chk("R6 one pulse only", 16'(exp_q.size()), 16'h0000);
    wr(3'd0, 16'h0000);

    // capture while counting, reload 0x2_0003
    wr(3'd2, 16'h0003);
    wr(3'd3, 16'h0002);
    wr(3'd1, 16'h0004);
    wait_cyc(10);
    wr(3'd4, 16'h0000);
    wait_cyc(7);
    rd_chk("R10 capture low", 3'd4, 16'hFFF9);
    rd_chk("R10 capture high", 3'd5, 16'h0001);
    wr(3'd2, 16'h0010);
    rd_chk("R4 reload write stops", 3'd0, 16'h0000);
    wr(3'd4, 16'h0000);
    rd_chk("R4 counter loaded low", 3'd4, 16'h0010);
    rd_chk("R4 counter loaded high", 3'd5, 16'h0002);

    wr(3'd1, 16'h000C);
    rd_chk("R3 stop beats start", 3'd0, 16'h0000);

    wait_cyc(10);
    chk("R9 all pulses seen", 16'(exp_q.size()), 16'h0000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired at cycle %0d, expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule